// File: doc/BRIEF.md
# Timer channel status flag register

This block is the 8-bit status register of one channel of a 16-bit up/down timer. It also holds the channel's counter and one compare/capture register, called D, so that the flags have real events to react to. The flags are sticky. One reports the direction of the last enabled count. Two report wrap-around of the counter. One reports a compare match or a capture on D. Three general event flags (A, B, C) are set by strobes from neighbouring logic.

Software reaches the register through a simple single-cycle bus: a read strobe with combinational read data, and a write strobe with write data. A flag can be cleared only by writing 0 to it after that same flag has been read as 1. Parameters select the channel variant:

- whether the direction bit exists;
- whether the underflow flag exists;
- whether flag D exists;
- whether a down-count from 1 to 0 also counts as an overflow.

Top module: `tmr_stat_reg`

## Requirements
- R1: After reset the status reads 0xC0 on every variant, and the counter and register D read 0.
- R2: Bit 7 reads 1 while the last enabled count was upward and 0 after an enabled downward count. On a variant without the direction bit, bit 7 always reads 1.
- R3: Bit 6 always reads 1, and writes to it have no effect.
- R4: Bit 4 (overflow) is set by an enabled upward count from 0xFFFF to 0x0000.
- R5: Bit 5 (underflow) is set by an enabled downward count from 0x0000 to 0xFFFF. On a variant without underflow support it always reads 0.
- R6: On the variant with the down-to-zero option, an enabled downward count from 0x0001 to 0x0000 also sets bit 4.
- R7: Bit 3 (flag D) has two set conditions, one for each mode of D.
  - In compare mode (capture select 0), it is set on the edge after any cycle in which the counter equals D.
  - In capture mode (capture select 1), a capture strobe copies the counter into D on the next edge, and bit 3 is set on that same edge.
  - On a variant without flag D, bit 3 always reads 0.
- R8: Writing 0 to a flag bit clears it only if a read since the last write returned 1 for that bit. Any write consumes that armed state. Writing 1 never changes a flag.
- R9: Bits 2, 1 and 0 (flags C, B, A) are set by event inputs 2, 1 and 0.
- R10: The counter behaves as follows.
  - A load takes priority over counting.
  - When enabled, it counts up or down by 1 and wraps modulo 2^16.
  - When disabled and not loading, it holds its value.
- R11: When a set event and a valid clear fall on the same edge, the flag stays 1.
- R12: A flag changes on the first clock edge after its event cycle, and the status read data reflects the flags without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Counter enable |
| cnt_up_i | input | 1 | Count direction, 1 = up |
| cnt_load_i | input | 1 | Synchronous counter load |
| cnt_load_val_i | input | 16 | Counter load value |
| d_cap_mode_i | input | 1 | Register D mode: 0 = compare, 1 = capture |
| d_cap_stb_i | input | 1 | Capture strobe for register D |
| d_wr_i | input | 1 | Write strobe for register D |
| d_wr_val_i | input | 16 | Value written to register D |
| evt_abc_i | input | 3 | Set events for flags C, B, A |
| reg_rd_i | input | 1 | Status read strobe |
| reg_wr_i | input | 1 | Status write strobe |
| reg_wdata_i | input | 8 | Status write data |
| reg_rdata_o | output | 8 | Status read data |
| cnt_o | output | 16 | Counter value |
| d_o | output | 16 | Register D value |

## Verification
The hardest situation to reach from the ports is an armed clear that lands on the same edge as a new overflow.

To get there, the stimulus first drives the counter through a wrap so that bit 4 is set. It then reads the status to arm the bit, loads 0xFFFF, and in the next cycle issues the write of 0 together with the wrapping up-count.

Two instances with opposite variant settings share all stimulus. This exposes the reserved-bit values and the down-to-zero overflow side by side. A reference model compares both instances every cycle, during the directed phases and during a stretch of random traffic near the wrap points.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  localparam int NFLAG   = 6;
  localparam int B_A     = 0;
  localparam int B_B     = 1;
  localparam int B_C     = 2;
  localparam int B_D     = 3;
  localparam int B_OVF   = 4;
  localparam int B_UDF   = 5;
  localparam int B_RSVD  = 6;
  localparam int B_DIR   = 7;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int CNT_W = 16,
  parameter bit CPWM  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             ovf_o,
  output logic             udf_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic             step;

  assign step = en_i && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      if (en_i) dir_q <= up_i;
      if (load_i)      cnt_q <= load_val_i;
      else if (en_i)   cnt_q <= up_i ? cnt_q + ONE : cnt_q - ONE;
    end
  end

  assign ovf_o = step && ((up_i && cnt_q == MAXV) || (CPWM && !up_i && cnt_q == ONE));
  assign udf_o = step && !up_i && cnt_q == '0;
  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  p_wrap_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && up_i && cnt_q == MAXV |=> cnt_q == '0);
  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_dreg.sv
module tmr_dreg #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_mode_i,
  input  logic             cap_stb_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  output logic [CNT_W-1:0] d_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       d_q <= '0;
    else if (cap_mode_i && cap_stb_i)  d_q <= cnt_i;
    else if (wr_i)                     d_q <= wr_val_i;
  end

  assign evt_o = cap_mode_i ? cap_stb_i : (cnt_i == d_q);
  assign d_o   = d_q;

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_mode_i && cap_stb_i |=> d_q == $past(cnt_i));
endmodule

// File: rtl/tmr_flag_bit.sv
module tmr_flag_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q, clr;

  // clear needs a prior read of 1 since the last write
  assign clr = wr_i && !wbit_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_i)                arm_q <= 1'b0;
      else if (rd_i && flag_q) arm_q <= 1'b1;
      if (set_i)               flag_q <= 1'b1;
      else if (clr)            flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_no_blind_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !arm_q |=> flag_q);
  p_armed_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wbit_i && arm_q && !set_i |=> !flag_q);
  p_write_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wbit_i && flag_q |=> flag_q);
endmodule

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg
  import tmr_stat_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit HAS_DIR   = 1'b1,
  parameter bit HAS_UDF   = 1'b1,
  parameter bit HAS_DFLAG = 1'b1,
  parameter bit CPWM      = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             cnt_up_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_load_val_i,
  input  logic             d_cap_mode_i,
  input  logic             d_cap_stb_i,
  input  logic             d_wr_i,
  input  logic [CNT_W-1:0] d_wr_val_i,
  input  logic [2:0]       evt_abc_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] d_o
);
  localparam flag_vec_t IMPL = {HAS_UDF, 1'b1, HAS_DFLAG, 3'b111};

  logic [CNT_W-1:0] cnt;
  logic             dir, ovf_evt, udf_evt, d_evt;
  flag_vec_t        set_vec, flags;

  tmr_cnt #(.CNT_W(CNT_W), .CPWM(CPWM)) u_cnt (
    .clk_i, .rst_ni,
    .en_i(cnt_en_i), .up_i(cnt_up_i), .load_i(cnt_load_i),
    .load_val_i(cnt_load_val_i), .cnt_o(cnt), .dir_o(dir),
    .ovf_o(ovf_evt), .udf_o(udf_evt)
  );

  tmr_dreg #(.CNT_W(CNT_W)) u_dreg (
    .clk_i, .rst_ni, .cnt_i(cnt),
    .cap_mode_i(d_cap_mode_i), .cap_stb_i(d_cap_stb_i),
    .wr_i(d_wr_i), .wr_val_i(d_wr_val_i), .d_o(d_o), .evt_o(d_evt)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[B_C:B_A] = evt_abc_i;
    set_vec[B_D]   = d_evt;
    set_vec[B_OVF] = ovf_evt;
    set_vec[B_UDF] = udf_evt;
  end

  for (genvar b = 0; b < NFLAG; b++) begin : g_flag
    if (IMPL[b]) begin : g_impl
      tmr_flag_bit u_bit (
        .clk_i, .rst_ni, .set_i(set_vec[b]), .rd_i(reg_rd_i),
        .wr_i(reg_wr_i), .wbit_i(reg_wdata_i[b]), .flag_o(flags[b])
      );
    end else begin : g_rsvd
      assign flags[b] = 1'b0;
    end
  end

  assign reg_rdata_o = {(HAS_DIR ? dir : 1'b1), 1'b1, flags};
  assign cnt_o       = cnt;

  p_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i |=> reg_rdata_o[B_DIR] == (HAS_DIR ? $past(cnt_up_i) : 1'b1));
  p_rsvd_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i |=> reg_rdata_o[B_RSVD]);
  p_ovf_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && !cnt_load_i && cnt_up_i && cnt == '1 |=> reg_rdata_o[B_OVF]);
endmodule

// File: tb/tmr_stat_reg_tb.sv
module tmr_stat_reg_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 0, up = 1, ld = 0, capm = 0, capstb = 0, dwr = 0, rd = 0, wr = 0;
  logic [15:0] ldv = 0, dval = 0;
  logic [2:0]  abc = 0;
  logic [7:0]  wd = 0;
  logic [7:0]  rdata [2];
  logic [15:0] cnt [2];
  logic [15:0] dq [2];
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_stat_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .cnt_up_i(up), .cnt_load_i(ld),
    .cnt_load_val_i(ldv), .d_cap_mode_i(capm), .d_cap_stb_i(capstb), .d_wr_i(dwr),
    .d_wr_val_i(dval), .evt_abc_i(abc), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata[0]), .cnt_o(cnt[0]), .d_o(dq[0]));

  tmr_stat_reg #(.HAS_DIR(1'b0), .HAS_UDF(1'b0), .HAS_DFLAG(1'b0), .CPWM(1'b1)) u_dut_alt (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(en), .cnt_up_i(up), .cnt_load_i(ld),
    .cnt_load_val_i(ldv), .d_cap_mode_i(capm), .d_cap_stb_i(capstb), .d_wr_i(dwr),
    .d_wr_val_i(dval), .evt_abc_i(abc), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata[1]), .cnt_o(cnt[1]), .d_o(dq[1]));

  // reference model
  localparam logic [5:0] MASK [2] = '{6'b111111, 6'b010111};
  localparam bit HASDIR [2] = '{1'b1, 1'b0};
  localparam bit OPT01  [2] = '{1'b0, 1'b1};
  logic [5:0]  mflag [2];
  logic [5:0]  marm  [2];
  logic        mdir;
  logic [15:0] mcnt, md;

  function automatic logic [7:0] mread(int v);
    return {(HASDIR[v] ? mdir : 1'b1), 1'b1, mflag[v] & MASK[v]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin mflag[v] = 0; marm[v] = 0; end
      mdir = 1; mcnt = 0; md = 0;
    end else begin
      for (int v = 0; v < 2; v++) begin
        logic [5:0] s;
        logic [7:0] r;
        r = mread(v);
        s[2:0] = abc;
        s[3] = capm ? capstb : (mcnt == md);
        s[4] = en && !ld && ((up && mcnt == 16'hFFFF) || (OPT01[v] && !up && mcnt == 16'h0001));
        s[5] = en && !ld && !up && mcnt == 16'h0000;
        s = s & MASK[v];
        for (int b = 0; b < 6; b++) begin
          logic armed;
          armed = marm[v][b];
          if (wr) marm[v][b] = 0;
          else if (rd && r[b]) marm[v][b] = 1;
          if (s[b]) mflag[v][b] = 1;
          else if (wr && !wd[b] && armed) mflag[v][b] = 0;
        end
      end
      if (capm && capstb) md = mcnt;
      else if (dwr) md = dval;
      if (en) mdir = up;
      if (ld) mcnt = ldv;
      else if (en) mcnt = up ? mcnt + 16'd1 : mcnt - 16'd1;
    end
  end

  function automatic string tag_of(logic [7:0] diff);
    if (diff[7]) return "R2";
    if (diff[6]) return "R3";
    if (diff[5]) return "R5";
    if (diff[4]) return "R4";
    if (diff[3]) return "R7";
    return "R9";
  endfunction

  // per-cycle comparison, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (rst_n && !done) begin
        for (int v = 0; v < 2; v++) begin
          checks++;
          if (rdata[v] !== mread(v)) begin
            errors++;
            $display("FAIL %s dut%0d status act=%h exp=%h", tag_of(rdata[v] ^ mread(v)), v, rdata[v], mread(v));
          end
          checks++;
          if (cnt[v] !== mcnt || dq[v] !== md) begin
            errors++;
            $display("FAIL R10 dut%0d cnt/d act=%h/%h exp=%h/%h", v, cnt[v], dq[v], mcnt, md);
          end
        end
      end
    end
  end

  task automatic chk(string tag, int v, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d act=%h exp=%h", tag, v, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic rdreg(); rd = 1; tick(); rd = 0; endtask
  task automatic wrreg(logic [7:0] v); wr = 1; wd = v; tick(); wr = 0; endtask
  task automatic load(logic [15:0] v); ld = 1; ldv = v; tick(); ld = 0; endtask
  task automatic run(logic dirup, int n); en = 1; up = dirup; repeat (n) tick(); en = 0; endtask
  task automatic clear_all(); rdreg(); wrreg(8'h00); endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    for (int v = 0; v < 2; v++) begin
      chk("R1", v, rdata[v], 8'hC0);
      chk("R1", v, cnt[v][7:0], 8'h00);
    end
    rst_n = 1;
    dval = 16'h0800; dwr = 1; tick(); dwr = 0;
    clear_all();
    // R4: overflow
    load(16'hFFFD); run(1, 3);
    chk("R4", 0, {7'd0, rdata[0][4]}, 8'd1);
    chk("R10", 0, cnt[0][7:0], 8'h00);
    // R8: blind clear, write-1, consumed arm, armed clear
    wrreg(8'h00);
    chk("R8", 0, {7'd0, rdata[0][4]}, 8'd1);
    rdreg(); wrreg(8'hFF); wrreg(8'h00);
    chk("R8", 0, {7'd0, rdata[0][4]}, 8'd1);
    chk("R3", 0, {7'd0, rdata[0][6]}, 8'd1);
    rdreg(); wrreg(8'hEF);
    chk("R8", 0, {7'd0, rdata[0][4]}, 8'd0);
    // R11: set wins over armed clear
    load(16'hFFFE); run(1, 2);
    rdreg(); load(16'hFFFF);
    en = 1; up = 1; wr = 1; wd = 8'h00; tick(); en = 0; wr = 0;
    chk("R11", 0, {7'd0, rdata[0][4]}, 8'd1);
    clear_all();
    // R5, R6, R2: down through 1->0->FFFF
    load(16'h0002); run(0, 3);
    chk("R5", 0, {7'd0, rdata[0][5]}, 8'd1);
    chk("R5", 1, {7'd0, rdata[1][5]}, 8'd0);
    chk("R6", 0, {7'd0, rdata[0][4]}, 8'd0);
    chk("R6", 1, {7'd0, rdata[1][4]}, 8'd1);
    chk("R2", 0, {7'd0, rdata[0][7]}, 8'd0);
    chk("R2", 1, {7'd0, rdata[1][7]}, 8'd1);
    chk("R10", 0, cnt[0][7:0], 8'hFF);
    // R7: compare match
    dval = 16'h0020; dwr = 1; tick(); dwr = 0;
    load(16'h001E); clear_all(); run(1, 3);
    chk("R7", 0, {7'd0, rdata[0][3]}, 8'd1);
    chk("R7", 1, {7'd0, rdata[1][3]}, 8'd0);
    chk("R2", 0, {7'd0, rdata[0][7]}, 8'd1);
    // R7: capture
    capm = 1; clear_all();
    chk("R7", 0, {7'd0, rdata[0][3]}, 8'd0);
    capstb = 1; tick(); capstb = 0;
    chk("R7", 0, {7'd0, rdata[0][3]}, 8'd1);
    chk("R7", 0, dq[0][7:0], 8'h21);
    capm = 0;
    dval = 16'h0900; dwr = 1; tick(); dwr = 0;
    // R9, R12: event flags one edge later
    clear_all();
    abc = 3'b101; tick(); abc = 0;
    chk("R9", 0, rdata[0] & 8'h07, 8'h05);
    chk("R12", 1, rdata[1] & 8'h07, 8'h05);
    // random traffic near wrap points
    for (int i = 0; i < 600; i++) begin
      en = $urandom_range(0, 3) != 0; up = $urandom_range(0, 1) == 1;
      ld = $urandom_range(0, 9) == 0;
      ldv = ($urandom_range(0, 1) == 1) ? 16'(16'hFFFE + $urandom_range(0, 3)) : 16'($urandom_range(0, 2));
      capm = $urandom_range(0, 5) == 0; capstb = $urandom_range(0, 3) == 0;
      dwr = $urandom_range(0, 7) == 0; dval = 16'($urandom_range(0, 3));
      abc = 3'($urandom_range(0, 7)) & {3{$urandom_range(0, 3) == 0}};
      rd = $urandom_range(0, 2) == 0; wr = $urandom_range(0, 3) == 0;
      wd = 8'($urandom_range(0, 255));
      tick();
    end
    {en, ld, capm, capstb, dwr, rd, wr} = '0; abc = 0;
    tick(); tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule